// File: doc/BRIEF.md
# Autoreload Baud Timer

This block is a 16-bit up-counting timer that serves as the bit clock source for a serial port. Each time the count rolls over from all ones, it reloads from a 16-bit reload value. The reload value is held as two byte registers. Every rollover produces a single-cycle tick. The serial logic samples each bit over 16 ticks, so the resulting bit rate is f_core / (16 × (65536 − reload)) when the timer counts the core clock.

The timer can count either the core clock or falling edges on an external count pin. Two select bits decide independently which directions use its tick:

- A direction whose select bit is set receives the timer tick.
- A direction whose select bit is clear passes through the tick of an alternate timer.
- Setting either select bit puts the block into baud mode.

A trigger pin with its own enable sets an external flag. In baud mode the normal overflow flag stays quiet. Software programs and clears everything through one byte-wide write port.

The counting engine is a three-state machine:

- **HALT**: entered from any state when the run bit is 0. The counter holds its value.
- **CORE**: entered when run is 1 and the source bit is 0. The counter advances once per core clock.
- **PIN**: entered when run is 1 and the source bit is 1. The counter advances once per detected pin fall.

The state is re-evaluated on every clock, so HALT→CORE, HALT→PIN, CORE↔PIN and CORE/PIN→HALT are all direct transitions. Control changes take effect on the clock after the state register follows them.

Top module: `baud_reload_timer`

## Requirements
- R1: After reset, the control byte, count and reload value are all zero. rx_tick, tx_tick and irq are 0. With the default reload of zero, the first tick after run is set comes 65536 counts later.
- R2: In CORE state the counter advances by one every clock. When it leaves 16'hFFFF it loads the reload value, so consecutive ticks are exactly 65536 − reload clocks apart.
- R3: Each rollover gives a one-cycle tick, in the cycle after the wrapping edge. It appears on rx_tick when control bit 0 (receive select) is 1, and on tx_tick when control bit 1 (transmit select) is 1. With both bits set, both outputs tick together.
- R4: A direction whose select bit is 0 drives alt_rx_tick or alt_tx_tick straight to its output. The timer tick is not seen on that output.
- R5: With control bit 3 (run) at 0, the count holds its value and no tick is produced.
- R6: With control bit 2 (source) at 1, the counter ignores the core clock. It advances once per falling edge of t_pin, detected after a two-flop synchronizer.
- R7: With control bit 4 (external enable) at 1, a synchronized falling edge on trig_pin sets the external flag (control bit 5) and raises irq. It never reloads or alters the count. With bit 4 at 0 the pin is ignored.
- R8: When neither select bit is set, a rollover sets the overflow flag (control bit 6), which raises irq. In baud mode a rollover leaves that flag unchanged.
- R9: Writing a reload byte (address 1 is the low byte, address 2 the high byte) leaves the current count unchanged. The new value is first used at the next rollover.
- R10: irq is the OR of control bits 5 and 6. Writing the control byte (address 0) with those bits at 0 clears them. A hardware set in the same cycle wins over the clear.
- R11: Writing address 3 or 4 replaces the low or high count byte. A count write takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1/2 reload low/high, 3/4 count low/high |
| reg_wdata | input | 8 | Write data |
| t_pin | input | 1 | External count input, falling edges counted |
| trig_pin | input | 1 | External trigger input, falling edges flagged |
| alt_rx_tick | input | 1 | Receive tick from the alternate timer |
| alt_tx_tick | input | 1 | Transmit tick from the alternate timer |
| rx_tick | output | 1 | Receive bit-clock tick |
| tx_tick | output | 1 | Transmit bit-clock tick |
| irq | output | 1 | Interrupt request (overflow or external flag) |

## Verification
The rollover period is measured for a range of reload values, from a three-cycle period up to 256 cycles, and under all three select patterns. This separates a wrong reload load, an off-by-one in the period, and mis-routing or a stretched tick between the two directions. The reset-default run covers a full 65536-count sweep, and a reload rewritten before running must not disturb the first period but must set the second. Pin-driven counting is tried with a stream of core clocks that must not count. Trigger tests compare a timed rollover with and without an intervening trigger edge, which exposes any reload caused by the trigger.

// File: rtl/abt_pkg.sv
package abt_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_CORE = 2'd1,
        ST_PIN  = 2'd2
    } tmr_state_e;

    // control byte, bit 0 is rx_sel
    typedef struct packed {
        logic ovf_flag;
        logic ext_flag;
        logic ext_en;
        logic run;
        logic src_pin;
        logic tx_sel;
        logic rx_sel;
    } ctrl_t;

    localparam int CTRL_BITS = 7;

endpackage

// File: rtl/abt_fall_detect.sv
module abt_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];

    // a detected edge lasts one cycle
    assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/abt_timer_core.sv
module abt_timer_core
    import abt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              src_pin,
    input  logic              pin_fall,
    input  logic [CNT_W-1:0]  rld,
    input  logic [NBYTES-1:0] cnt_wr_en,
    input  logic [BYTE_W-1:0] cnt_wr_data,
    output logic              ovf
);

    tmr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic inc;
    logic wrap;
    logic any_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run) state_d = src_pin ? ST_PIN : ST_CORE;
            ST_CORE: if (!run) state_d = ST_HALT;
                     else if (src_pin) state_d = ST_PIN;
            ST_PIN:  if (!run) state_d = ST_HALT;
                     else if (!src_pin) state_d = ST_CORE;
            default: state_d = ST_HALT;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        inc = 1'b0;
        unique case (state_q)
            ST_HALT: inc = 1'b0;
            ST_CORE: inc = 1'b1;
            ST_PIN:  inc = pin_fall;
            default: inc = 1'b0;
        endcase
    end

    assign any_wr = |cnt_wr_en;
    assign wrap   = (cnt_q == {CNT_W{1'b1}});

    always_comb begin
        cnt_d = cnt_q;
        if (any_wr) begin
            for (int i = 0; i < NBYTES; i++)
                if (cnt_wr_en[i]) cnt_d[i*BYTE_W +: BYTE_W] = cnt_wr_data;
        end else if (inc) begin
            cnt_d = wrap ? rld : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ovf   <= inc & wrap & ~any_wr;
        end
    end

    assert_reload_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> cnt_q == $past(rld));

    assert_hold_when_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !any_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/abt_tick_router.sv
module abt_tick_router #(
    parameter int NDIR = 2
) (
    input  logic            tick,
    input  logic [NDIR-1:0] sel,
    input  logic [NDIR-1:0] alt,
    output logic [NDIR-1:0] out
);

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        assign out[d] = sel[d] ? tick : alt[d];
    end

endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer
    import abt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              t_pin,
    input  logic              trig_pin,
    input  logic              alt_rx_tick,
    input  logic              alt_tx_tick,
    output logic              rx_tick,
    output logic              tx_tick,
    output logic              irq
);

    localparam int NBYTES   = CNT_W / BYTE_W;
    localparam int RLD_BASE = 1;
    localparam int CNT_BASE = 1 + NBYTES;

    ctrl_t ctrl_q;
    logic [CNT_W-1:0]  rld_q;
    logic [NBYTES-1:0] rld_wr_en;
    logic [NBYTES-1:0] cnt_wr_en;
    logic ctrl_wr;
    logic t_fall, trig_fall;
    logic ovf;
    logic baud_mode;
    logic [1:0] routed;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_W'(0));
    assign baud_mode = ctrl_q.rx_sel | ctrl_q.tx_sel;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign rld_wr_en[b] = reg_wr && (reg_addr == ADDR_W'(RLD_BASE + b));
        assign cnt_wr_en[b] = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            rld_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (rld_wr_en[b]) rld_q[b*BYTE_W +: BYTE_W] <= reg_wdata;
        end
    end

    // control byte; hardware flag sets win over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
            if (ovf && !baud_mode) ctrl_q.ovf_flag <= 1'b1;
            if (trig_fall && ctrl_q.ext_en) ctrl_q.ext_flag <= 1'b1;
        end
    end

    abt_fall_detect #(.STAGES(SYNC_STAGES)) u_t_edge (
        .clk(clk), .rst_n(rst_n), .pin(t_pin), .fall(t_fall));

    abt_fall_detect #(.STAGES(SYNC_STAGES)) u_trig_edge (
        .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

    abt_timer_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl_q.run), .src_pin(ctrl_q.src_pin), .pin_fall(t_fall),
        .rld(rld_q), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(reg_wdata),
        .ovf(ovf));

    abt_tick_router #(.NDIR(2)) u_route (
        .tick(ovf),
        .sel({ctrl_q.tx_sel, ctrl_q.rx_sel}),
        .alt({alt_tx_tick, alt_rx_tick}),
        .out(routed));

    assign rx_tick = routed[0];
    assign tx_tick = routed[1];
    assign irq     = ctrl_q.ovf_flag | ctrl_q.ext_flag;

    assert_no_ovf_flag_in_baud_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_mode && !ctrl_q.ovf_flag && !ctrl_wr) |=> !ctrl_q.ovf_flag);

    assert_ext_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ext_en && !ctrl_wr) |=> (ctrl_q.ext_flag == $past(ctrl_q.ext_flag)));

endmodule

// File: tb/sim_baud_reload_timer.sv
module sim_baud_reload_timer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic t_pin = 1'b1, trig_pin = 1'b1;
    logic alt_rx_tick = 1'b0, alt_tx_tick = 1'b0;
    logic rx_tick, tx_tick, irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    baud_reload_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .t_pin(t_pin), .trig_pin(trig_pin),
        .alt_rx_tick(alt_rx_tick), .alt_tx_tick(alt_tx_tick),
        .rx_tick(rx_tick), .tx_tick(tx_tick), .irq(irq));

    // control bits
    localparam logic [7:0] C_RX = 8'h01, C_TX = 8'h02, C_SRC = 8'h04,
                           C_RUN = 8'h08, C_EXT = 8'h10;

    // {select[1:0], reload[15:0]}: select 01 rx, 10 tx, 11 both
    localparam logic [17:0] VEC [0:5] = '{
        18'h1FFF0, 18'h2FFE0, 18'h3FFFC, 18'h1FF00, 18'h2FFFD, 18'h3FFF8};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic setup(input logic [15:0] rld, input logic [15:0] cnt);
        wr(3'd0, 8'h00);
        wr(3'd1, rld[7:0]);  wr(3'd2, rld[15:8]);
        wr(3'd3, cnt[7:0]);  wr(3'd4, cnt[15:8]);
    endtask

    function automatic logic pick(input bit use_tx);
        return use_tx ? tx_tick : rx_tick;
    endfunction

    task automatic wait_tick(input bit use_tx, input int limit, output int c);
        c = 0;
        while (!pick(use_tx) && c < limit) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int c;
        bit seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rx_tick == 0 && tx_tick == 0, "R1 ticks after reset", rx_tick + tx_tick, 0);
        chk(irq == 0, "R1 irq after reset", irq, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(rx_tick == 0 && irq == 0, "R5 idle after reset, run clear", rx_tick, 0);

        // vector table: periods and routing (R2 R3 R8)
        for (int v = 0; v < 6; v++) begin
            logic [15:0] rld;
            logic [1:0] sel;
            bit use_tx;
            int per;
            rld = VEC[v][15:0];
            sel = VEC[v][17:16];
            use_tx = !sel[0];
            per = 65536 - int'(rld);
            setup(rld, rld);
            wr(3'd0, {6'b0, sel} | C_RUN);
            wait_tick(use_tx, 1000, c);
            chk(pick(use_tx) == 1, "R2 first tick seen", pick(use_tx), 1);
            if (sel == 2'b11) chk(rx_tick == tx_tick, "R3 both outputs together", tx_tick, rx_tick);
            else chk(pick(!use_tx) == 0, "R3 unselected output quiet", pick(!use_tx), 0);
            @(negedge clk);
            chk(pick(use_tx) == 0, "R3 tick lasts one cycle", pick(use_tx), 0);
            c = 1;
            while (!pick(use_tx) && c < 1000) begin
                @(negedge clk);
                c++;
            end
            chk(c == per, "R2 rollover period", c, per);
            chk(irq == 0, "R8 no overflow flag in baud mode", irq, 0);
        end

        // R4 alternate source pass-through
        setup(16'h0000, 16'h0000);
        wr(3'd0, C_RX);
        @(negedge clk);
        alt_tx_tick = 1'b1; alt_rx_tick = 1'b1;
        #1;
        chk(tx_tick == 1, "R4 unselected tx follows alternate", tx_tick, 1);
        chk(rx_tick == 0, "R4 selected rx ignores alternate", rx_tick, 0);
        @(negedge clk);
        alt_tx_tick = 1'b0; alt_rx_tick = 1'b0;

        // R5 hold while halted, then resume (R11 count write)
        setup(16'hFFF0, 16'hFFFE);
        wr(3'd0, C_RX);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            seen |= rx_tick;
        end
        chk(seen == 0, "R5 no tick while run clear", seen, 0);
        wr(3'd0, C_RX | C_RUN);
        wait_tick(1'b0, 100, c);
        chk(c == 3, "R11 resumes from written count", c, 3);

        // R9 reload rewrite while halted leaves count, used at next wrap
        setup(16'hFFF0, 16'hFFE0);
        wr(3'd1, 8'hFC);
        wr(3'd0, C_RX | C_RUN);
        wait_tick(1'b0, 1000, c);
        chk(c == 33, "R9 count unchanged by reload write", c, 33);
        @(negedge clk);
        c = 1;
        while (!rx_tick && c < 1000) begin
            @(negedge clk);
            c++;
        end
        chk(c == 4, "R9 new reload used at next rollover", c, 4);

        // R6 pin source
        setup(16'hFFF0, 16'hFFFE);
        wr(3'd0, C_RX | C_SRC | C_RUN);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            seen |= rx_tick;
        end
        chk(seen == 0, "R6 core clock ignored in pin mode", seen, 0);
        t_pin = 1'b0;
        repeat (5) begin @(negedge clk); seen |= rx_tick; end
        t_pin = 1'b1;
        repeat (5) begin @(negedge clk); seen |= rx_tick; end
        chk(seen == 0, "R6 one pin fall, no rollover yet", seen, 0);
        t_pin = 1'b0;
        wait_tick(1'b0, 10, c);
        chk(rx_tick == 1, "R6 second pin fall rolls over", rx_tick, 1);
        t_pin = 1'b1;

        // R7 trigger: flag set, no reload
        setup(16'hFF00, 16'hFFFD);
        wr(3'd0, C_RX | C_EXT);
        trig_pin = 1'b0;
        repeat (6) @(negedge clk);
        trig_pin = 1'b1;
        chk(irq == 1, "R7 trigger sets external flag", irq, 0 + 1);
        wr(3'd0, C_RX | C_EXT | C_RUN);
        wait_tick(1'b0, 1000, c);
        chk(c == 4, "R7 trigger did not reload count", c, 4);
        // R10 clear by writing zero
        wr(3'd0, C_RX);
        chk(irq == 0, "R10 flag cleared by write", irq, 0);
        trig_pin = 1'b0;
        repeat (6) @(negedge clk);
        trig_pin = 1'b1;
        chk(irq == 0, "R7 trigger ignored with enable clear", irq, 0);

        // R8 non-baud overflow raises flag
        setup(16'hFFF0, 16'hFFFE);
        wr(3'd0, C_RUN);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            seen |= rx_tick | tx_tick;
        end
        chk(irq == 1, "R8 overflow flag outside baud mode", irq, 1);
        chk(seen == 0, "R4 no timer tick when unselected", seen, 0);
        wr(3'd0, 8'h00);
        chk(irq == 0, "R10 overflow flag cleared", irq, 0);

        // R1 default reload zero: full sweep from reset count
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr(3'd0, C_RX | C_RUN);
        wait_tick(1'b0, 70000, c);
        chk(c == 65537, "R1 first tick after full sweep", c, 65537);

        finish_run();
    end

endmodule